// File: doc/BRIEF.md
# Configurable Input Cell Port

This block conditions a bank of external input pins before their values reach a programmable logic array. Each pin has its own cell, which passes the pin straight through, holds it in a level-sensitive latch, or captures it in an edge-triggered register. The cell outputs drive the logic array's input bus. A host can also read them over its data bus.

The latch enable or capture strobe of each cell comes from a per-group selector. Each group is a nibble of four neighbouring pins. The selector picks either that group's logic-array product term or the host's address-latch strobe. With the address strobe selected, the port catches the high address bits of a multiplexed bus as they appear on the pins. With a product term selected, an external processor can strobe data into the cells through decode of its own chip select and write signal, and the host then reads the data back. This gives a mailbox path between two processors.

All sequential behaviour runs on one system clock. Strobes are sampled at its rising edge, and a strobe "rise" means the strobe was low at the previous clock edge and is high at the current one.

Top module: `imc_port`

## Requirements
- R1: A cell in pass mode (mode code 00) drives its pin value onto its output in the same cycle, with no clock edge in between.
- R2: A cell in latch mode (mode code 01) drives its pin value while its selected enable is high. At each clock edge where the enable is high, it stores the pin value. While the enable is low, it outputs the stored value.
- R3: A cell in register mode (mode code 10) stores its pin value at a clock edge where its selected strobe rises. Its output shows the stored value from that edge on and ignores the pin at every other edge, including edges where the strobe stays high or falls.
- R4: Strobe select bit 0 of a group uses that group's product term, `pt_i[g]`. Select bit 1 uses `ale_i`. The signal that is not selected has no effect on the group.
- R5: Group g covers pins 4g to 4g+3. A product term strobes only the cells of its own group.
- R6: When `cfg_we_i` is high at a clock edge, the configuration loads from `cfg_wdata_i`. Bits [2i+1:2i] hold the mode of pin i, and bit 2*NUM_PINS+g holds the strobe select of group g. Mode code 11 behaves as pass. With `cfg_we_i` low, `cfg_wdata_i` has no effect.
- R7: Reset sets every cell to pass mode with the product-term strobe and clears every stored cell value to 0.
- R8: With `host_rd_i` high, `host_rdata_o` bit i is the output of cell i. With `host_rd_i` low, `host_rdata_o` is 0.
- R9: `array_o` bit i always carries the output of cell i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_PINS | External pin values |
| pt_i | input | NUM_GRP | Per-group product-term strobe |
| ale_i | input | 1 | Host address-latch strobe |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_wdata_i | input | CFG_W | Configuration write data |
| host_rd_i | input | 1 | Host read strobe |
| host_rdata_o | output | NUM_PINS | Host read data, 0 when not reading |
| array_o | output | NUM_PINS | Cell outputs to the logic array input bus |

## Verification
The bench builds the block with its default values: eight pins in two groups of four. With two groups, one test can put different modes and different strobe sources on the two nibbles at once. It can also show that one group's product term leaves the other group untouched. The vector sequence moves one set of stored values through pass, latch, register, address-strobe and mixed configurations. This shows that stored state survives mode changes, and that a new configuration takes effect only after the edge that loads it.

// File: rtl/imc_pkg.sv
package imc_pkg;
  typedef enum logic [1:0] {
    MODE_PASS  = 2'b00,
    MODE_LATCH = 2'b01,
    MODE_REG   = 2'b10,
    MODE_RSVD  = 2'b11
  } cell_mode_e;

  localparam int unsigned MODE_W = 2;
endpackage

// File: rtl/imc_cfg_reg.sv
module imc_cfg_reg #(
  parameter int unsigned CFG_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] cfg_o
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= wdata_i;
  end

  assign cfg_o = cfg_q;

  p_cfg_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cfg_q));
  p_cfg_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> cfg_q == $past(wdata_i));
endmodule

// File: rtl/imc_strobe_sel.sv
module imc_strobe_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_ale_i,
  input  logic pt_i,
  input  logic ale_i,
  output logic en_o,
  output logic rise_o
);
  logic strb;
  logic strb_q;

  assign strb = sel_ale_i ? ale_i : pt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strb_q <= 1'b0;
    else         strb_q <= strb;
  end

  assign en_o   = strb;
  assign rise_o = strb & ~strb_q;

  p_rise_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/imc_cell.sv
module imc_cell
  import imc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  cell_mode_e mode_i,
  input  logic       en_i,
  input  logic       rise_i,
  input  logic       pin_i,
  output logic       out_o
);
  logic held_q;
  logic load;

  always_comb begin
    unique case (mode_i)
      MODE_LATCH: load = en_i;
      MODE_REG:   load = rise_i;
      default:    load = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   held_q <= 1'b0;
    else if (load) held_q <= pin_i;
  end

  always_comb begin
    unique case (mode_i)
      MODE_LATCH: out_o = en_i ? pin_i : held_q;
      MODE_REG:   out_o = held_q;
      default:    out_o = pin_i;
    endcase
  end

  p_latch_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_LATCH && en_i) |=> held_q == $past(pin_i));
  p_latch_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_LATCH && !en_i) |=> $stable(held_q));
  p_reg_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_REG && rise_i) |=> held_q == $past(pin_i));
  p_reg_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_REG && !rise_i) |=> $stable(held_q));
endmodule

// File: rtl/imc_port.sv
module imc_port
  import imc_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned GRP_W    = 4,
  localparam int unsigned NUM_GRP = NUM_PINS / GRP_W,
  localparam int unsigned CFG_W   = MODE_W * NUM_PINS + NUM_GRP
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_GRP-1:0]  pt_i,
  input  logic                ale_i,
  input  logic                cfg_we_i,
  input  logic [CFG_W-1:0]    cfg_wdata_i,
  input  logic                host_rd_i,
  output logic [NUM_PINS-1:0] host_rdata_o,
  output logic [NUM_PINS-1:0] array_o
);
  localparam int unsigned SEL_LSB = MODE_W * NUM_PINS;

  logic [CFG_W-1:0]    cfg;
  logic [NUM_GRP-1:0]  grp_en;
  logic [NUM_GRP-1:0]  grp_rise;
  logic [NUM_PINS-1:0] cell_out;

  imc_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    imc_strobe_sel u_sel (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sel_ale_i (cfg[SEL_LSB+g]),
      .pt_i      (pt_i[g]),
      .ale_i     (ale_i),
      .en_o      (grp_en[g]),
      .rise_o    (grp_rise[g])
    );
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_cell
    imc_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .mode_i (cell_mode_e'(cfg[MODE_W*i +: MODE_W])),
      .en_i   (grp_en[i/GRP_W]),
      .rise_i (grp_rise[i/GRP_W]),
      .pin_i  (pin_i[i]),
      .out_o  (cell_out[i])
    );
  end

  assign array_o      = cell_out;
  assign host_rdata_o = host_rd_i ? cell_out : '0;

  p_rd_mirror_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rd_i |-> host_rdata_o == array_o);
endmodule

// File: tb/imc_port_tb_top.sv
module imc_port_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NP = 8;
  localparam int unsigned NG = 2;
  localparam int unsigned CW = 18;
  localparam int unsigned NV = 18;
  localparam int unsigned EW = 1 + CW + NG + 1 + 1 + NP + NP;

  // we, cfg, pt, ale, rd, pin, expected array
  localparam logic [EW-1:0] VEC [NV] = '{
    {1'b1, 18'h00000, 2'b00, 1'b0, 1'b1, 8'hA5, 8'hA5},
    {1'b0, 18'h00000, 2'b00, 1'b0, 1'b0, 8'h3C, 8'h3C},
    {1'b1, 18'h05555, 2'b11, 1'b0, 1'b1, 8'h96, 8'h96},
    {1'b0, 18'h05555, 2'b11, 1'b0, 1'b0, 8'hF0, 8'hF0},
    {1'b0, 18'h05555, 2'b00, 1'b0, 1'b1, 8'h0F, 8'hF0},
    {1'b0, 18'h05555, 2'b01, 1'b0, 1'b0, 8'hAA, 8'hFA},
    {1'b0, 18'h05555, 2'b00, 1'b0, 1'b1, 8'h55, 8'hFA},
    {1'b1, 18'h0AAAA, 2'b00, 1'b0, 1'b0, 8'h33, 8'hFA},
    {1'b0, 18'h0AAAA, 2'b11, 1'b0, 1'b1, 8'hC3, 8'hC3},
    {1'b0, 18'h0AAAA, 2'b11, 1'b0, 1'b0, 8'h00, 8'hC3},
    {1'b0, 18'h0AAAA, 2'b00, 1'b0, 1'b1, 8'hFF, 8'hC3},
    {1'b0, 18'h0AAAA, 2'b10, 1'b0, 1'b0, 8'h5A, 8'h53},
    {1'b1, 18'h3AAAA, 2'b00, 1'b0, 1'b1, 8'h00, 8'h53},
    {1'b0, 18'h3AAAA, 2'b00, 1'b1, 1'b0, 8'hE7, 8'hE7},
    {1'b0, 18'h3AAAA, 2'b11, 1'b0, 1'b1, 8'h18, 8'hE7},
    {1'b1, 18'h100AA, 2'b00, 1'b0, 1'b0, 8'h12, 8'h17},
    {1'b0, 18'h100AA, 2'b00, 1'b1, 1'b1, 8'h9C, 8'h9C},
    {1'b1, 18'h0FFFF, 2'b00, 1'b0, 1'b0, 8'h6B, 8'h6B}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NP-1:0] pin_i = '0;
  logic [NG-1:0] pt_i = '0;
  logic          ale_i = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [CW-1:0] cfg_wdata_i = '0;
  logic          host_rd_i = 1'b0;
  logic [NP-1:0] host_rdata_o;
  logic [NP-1:0] array_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  imc_port #(.NUM_PINS(NP), .GRP_W(4)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .pt_i(pt_i), .ale_i(ale_i),
    .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i), .host_rd_i(host_rd_i),
    .host_rdata_o(host_rdata_o), .array_o(array_o)
  );

  task automatic check(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #2;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R7: during reset all cells pass
    pin_i = 8'h3C;
    repeat (3) @(posedge clk_i);
    #2;
    check("R7 reset pass", array_o, 8'h3C);
    rst_ni = 1'b1;

    // vector table: R1 R2 R3 R4 R5 R6 R8 R9
    for (int k = 0; k < NV; k++) begin
      logic [EW-1:0] v;
      v = VEC[k];
      {cfg_we_i, cfg_wdata_i, pt_i, ale_i, host_rd_i, pin_i} = v[EW-1:NP];
      tick();
      check("R9 array", array_o, v[NP-1:0]);
      check("R8 host read", host_rdata_o, host_rd_i ? v[NP-1:0] : '0);
    end

    // R6: write data ignored without enable
    cfg_we_i = 1'b0; cfg_wdata_i = 18'h0AAAA; pt_i = 2'b00; ale_i = 1'b0;
    pin_i = 8'hC3;
    tick();
    check("R6 ignore wdata", array_o, 8'hC3);
    pin_i = 8'h3C;
    #1;
    check("R1 comb pass", array_o, 8'h3C);

    // R7: mid-run reset clears config and stored values
    rst_ni = 1'b0; pin_i = 8'h44;
    #1;
    check("R7 async cfg clear", array_o, 8'h44);
    tick();
    rst_ni = 1'b1;
    cfg_we_i = 1'b1; cfg_wdata_i = 18'h0AAAA;
    tick();
    cfg_we_i = 1'b0;
    check("R7 held cleared", array_o, 8'h00);

    // R4: ALE ignored while product term selected
    ale_i = 1'b1; pin_i = 8'hFF;
    tick();
    check("R4 ale unselected", array_o, 8'h00);
    ale_i = 1'b0;
    pt_i = 2'b01;
    tick();
    check("R5 group0 only", array_o, 8'h0F);

    // R8: read idle returns zero
    host_rd_i = 1'b0;
    #1;
    check("R8 idle zero", host_rdata_o, 8'h00);
    host_rd_i = 1'b1;
    #1;
    check("R8 read", host_rdata_o, 8'h0F);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule